// File: doc/BRIEF.md
# Transmit Command and Station-Address Controller

This block sits on the register side of a small Ethernet MAC with two transmit buffers, each 2 KB wide in a 4 KB window. Software fills a buffer, sets its byte count, and then writes that buffer's control word. A two-bit command field in the control word selects the action. One command asks a downstream byte streamer to send the buffer's contents. The other copies the first six bytes of the buffer into the station MAC address.

Both command bits read back as set until the action completes. The send command clears when the streamer reports the end of the frame. The address load clears one cycle after it is issued. On completion, the block may raise a one-cycle interrupt pulse. This requires the buffer's own interrupt-enable bit, and also a master enable bit that exists only in buffer 0's address range.

Frames leave through a valid/ready start handshake that carries the buffer base and the length. Only one frame is in flight at a time.

Top module: `tx_cmd_ctrl`

## Requirements
- R1: After reset, every register reads 0, `fs_valid` and `irq` are low and `mac_addr` is 0.
- R2: The length register of each buffer (offset 0x7F4 from the buffer base) holds a 16-bit byte count taken from data bits 15:0. Any value above 1514 is stored as 1514.
- R3: The master interrupt enable lives at offset 0x7F8 of buffer 0 and keeps only data bit 31. It reads back in bit 31 with every other bit 0. The same offset in buffer 1 stores nothing and reads 0.
- R4: A write whose address bits 1:0 are not zero changes no register and starts no command.
- R5: The control register sits at offset 0x7FC from the buffer base. A write with bit 0 = 1 and bit 1 = 0 starts a send. After that write, `fs_valid` rises with `fs_base` equal to the buffer base (0x000 or 0x800) and `fs_len` equal to its length register. Bit 0 reads 1 until `tx_done` ends the frame.
- R6: An offer that is not accepted keeps `fs_valid` high with the same `fs_base`, even if the other buffer is commanded meanwhile. With both buffers pending and no offer yet standing, buffer 0 goes first. After acceptance, `fs_valid` stays low until `tx_done`.
- R7: A control write with bits 1:0 = 11 reads back with both bits set for one cycle. On the next clock edge, `mac_addr` becomes {b0,b1,b2,b3,b4,b5}, where bytes b0..b3 are word 0 of that buffer (b0 in data bits 7:0) and b4,b5 are bits 7:0 and 15:8 of word 1. The bits then clear and no frame is offered.
- R8: Control bit 3 is the buffer's interrupt enable and reads back. In the cycle after a completion, `irq` is high for exactly one cycle, provided the completing buffer's bit 3 and the master enable are both set. Otherwise `irq` stays low.
- R9: A control write with bit 0 = 1 to a buffer whose bit 0 already reads 1 is ignored entirely, including its bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| fs_valid | output | 1 | Frame start offered |
| fs_ready | input | 1 | Streamer accepts the offered frame |
| fs_base | output | 12 | Base byte address of the frame's buffer |
| fs_len | output | 16 | Frame length in bytes |
| tx_done | input | 1 | Streamer finished the frame in flight |
| irq | output | 1 | One-cycle completion interrupt |
| mac_addr | output | 48 | Station MAC address |

## Verification
The bench targets these cases:
- Lengths at and just past the 1514 cap, and a value that only fits in 16 bits. A wrong comparison would let 1515 or 65535 through.
- A misaligned control write. A design that decodes only the upper address bits would start a frame from it.
- A second send to a busy buffer that also clears bit 3. If the design accepted it, the completion interrupt would be lost.
- A send on buffer 0 while buffer 1 is on offer. A naive priority picker would swap `fs_base` under a pending handshake.
- A completion with the master enable clear, where an ungated design would still pulse.

// File: rtl/tx_cmd_ctrl.sv
module tx_cmd_ctrl #(
  parameter int AW      = 12,
  parameter int LW      = 16,
  parameter int MAX_LEN = 1514
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          fs_valid,
  input  logic          fs_ready,
  output logic [AW-1:0] fs_base,
  output logic [LW-1:0] fs_len,
  input  logic          tx_done,
  output logic          irq,
  output logic [47:0]   mac_addr
);
  localparam int HALF = 1 << (AW - 1);
  localparam logic [AW-2:0] OFF_LEN = (AW-1)'(HALF - 12);
  localparam logic [AW-2:0] OFF_GIE = (AW-1)'(HALF - 8);
  localparam logic [AW-2:0] OFF_CTL = (AW-1)'(HALF - 4);
  localparam logic [AW-2:0] OFF_W0  = '0;
  localparam logic [AW-2:0] OFF_W1  = (AW-1)'(4);
  localparam logic [LW-1:0] CAP     = LW'(MAX_LEN);

  logic [LW-1:0] len_r [2];
  logic [31:0]   w0_r [2];
  logic [15:0]   w1_r [2];
  logic [1:0]    ie_r, send_r, prog_r, pend_r;
  logic          gie_r, active_r, act_buf, load_q, load_buf, hold_r, hold_buf;

  logic          wbuf, rbuf, we, sel, fire, done_ev;
  logic [AW-2:0] woff, roff;

  assign wbuf    = wr_addr[AW-1];
  assign woff    = wr_addr[AW-2:0];
  assign we      = wr_en && (wr_addr[1:0] == 2'b00);
  assign rbuf    = rd_addr[AW-1];
  assign roff    = rd_addr[AW-2:0];
  assign sel     = hold_r ? hold_buf : !pend_r[0];
  assign fs_valid = !active_r && |pend_r;
  assign fs_base = {sel, {(AW-1){1'b0}}};
  assign fs_len  = len_r[sel];
  assign fire    = fs_valid && fs_ready;
  assign done_ev = tx_done && active_r;

  always_comb begin
    rd_data = '0;
    if (roff == OFF_LEN)
      rd_data[LW-1:0] = len_r[rbuf];
    else if (roff == OFF_GIE && !rbuf)
      rd_data[31] = gie_r;
    else if (roff == OFF_CTL)
      rd_data[3:0] = {ie_r[rbuf], 1'b0, prog_r[rbuf], send_r[rbuf]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        len_r[i] <= '0;
        w0_r[i]  <= '0;
        w1_r[i]  <= '0;
      end
      ie_r     <= '0;
      send_r   <= '0;
      prog_r   <= '0;
      pend_r   <= '0;
      gie_r    <= 1'b0;
      active_r <= 1'b0;
      act_buf  <= 1'b0;
      load_q   <= 1'b0;
      load_buf <= 1'b0;
      hold_r   <= 1'b0;
      hold_buf <= 1'b0;
      irq      <= 1'b0;
      mac_addr <= '0;
    end else begin
      irq      <= gie_r && ((load_q && ie_r[load_buf]) || (done_ev && ie_r[act_buf]));
      hold_r   <= fs_valid && !fs_ready;
      hold_buf <= sel;
      load_q   <= 1'b0;

      if (load_q) begin
        mac_addr <= {w0_r[load_buf][7:0], w0_r[load_buf][15:8], w0_r[load_buf][23:16],
                     w0_r[load_buf][31:24], w1_r[load_buf][7:0], w1_r[load_buf][15:8]};
        send_r[load_buf] <= 1'b0;
        prog_r[load_buf] <= 1'b0;
      end

      if (fire) begin
        pend_r[sel] <= 1'b0;
        active_r    <= 1'b1;
        act_buf     <= sel;
      end

      if (done_ev) begin
        active_r        <= 1'b0;
        send_r[act_buf] <= 1'b0;
      end

      if (we) begin
        if (woff == OFF_W0) w0_r[wbuf] <= wr_data;
        if (woff == OFF_W1) w1_r[wbuf] <= wr_data[15:0];
        if (woff == OFF_LEN)
          len_r[wbuf] <= (wr_data[LW-1:0] > CAP) ? CAP : wr_data[LW-1:0];
        if (woff == OFF_GIE && !wbuf) gie_r <= wr_data[31];
        if (woff == OFF_CTL && !(send_r[wbuf] && wr_data[0])) begin
          ie_r[wbuf] <= wr_data[3];
          if (wr_data[1:0] == 2'b01) begin
            send_r[wbuf] <= 1'b1;
            pend_r[wbuf] <= 1'b1;
          end else if (wr_data[1:0] == 2'b11) begin
            send_r[wbuf] <= 1'b1;
            prog_r[wbuf] <= 1'b1;
            load_q       <= 1'b1;
            load_buf     <= wbuf;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tx_cmd_ctrl_chk.sv
module tx_cmd_ctrl_chk #(
  parameter int AW      = 12,
  parameter int LW      = 16,
  parameter int MAX_LEN = 1514
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fs_valid,
  input logic          fs_ready,
  input logic [AW-1:0] fs_base,
  input logic [LW-1:0] fs_len,
  input logic          irq,
  input logic [47:0]   mac_addr,
  input logic          gie,
  input logic          load_q
);
  // R6
  fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid && !fs_ready |=> fs_valid && $stable(fs_base));

  // R2
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid |-> fs_len <= LW'(MAX_LEN));

  // R5
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid |-> fs_base[AW-2:0] == '0);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(gie));

  // R7
  mac_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mac_addr) |-> $past(load_q));
endmodule

bind tx_cmd_ctrl tx_cmd_ctrl_chk #(.AW(AW), .LW(LW), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_valid(fs_valid), .fs_ready(fs_ready),
  .fs_base(fs_base), .fs_len(fs_len), .irq(irq), .mac_addr(mac_addr),
  .gie(gie_r), .load_q(load_q)
);

// File: tb/test_tx_cmd_ctrl.sv
module test_tx_cmd_ctrl;
  logic        clk = 0, rst_n = 0, wr_en = 0, fs_ready = 0, tx_done = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0, fs_base;
  logic [31:0] wr_data = 0, rd_data;
  logic        fs_valid, irq;
  logic [15:0] fs_len;
  logic [47:0] mac_addr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tx_cmd_ctrl i_tx_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fs_valid(fs_valid), .fs_ready(fs_ready),
    .fs_base(fs_base), .fs_len(fs_len), .tx_done(tx_done), .irq(irq), .mac_addr(mac_addr)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NV = 10;
  localparam logic [87:0] VEC [NV] = '{
    {12'h7F4, 32'd1000,      12'h7F4, 32'd1000},       // R2
    {12'h7F4, 32'd1514,      12'h7F4, 32'd1514},       // R2
    {12'h7F4, 32'd1515,      12'h7F4, 32'd1514},       // R2
    {12'h7F4, 32'h0001FFFF,  12'h7F4, 32'd1514},       // R2
    {12'hFF4, 32'd60,        12'hFF4, 32'd60},         // R2
    {12'h7F6, 32'd99,        12'h7F4, 32'd1514},       // R4
    {12'h7F8, 32'hFFFFFFFF,  12'h7F8, 32'h80000000},   // R3
    {12'hFF8, 32'h80000000,  12'hFF8, 32'h0},          // R3
    {12'h7F8, 32'h7FFFFFFF,  12'h7F8, 32'h0},          // R3
    {12'hFFD, 32'h00000009,  12'hFFC, 32'h0}           // R4
  };

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic accept_done();
    fs_ready = 1;
    @(negedge clk);
    fs_ready = 0;
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(12'h7FC, d); chk("R1 ctrl0", d, 0);
    rd(12'h7F4, d); chk("R1 len0", d, 0);
    rd(12'h7F8, d); chk("R1 gie", d, 0);
    chk("R1 fs_valid", fs_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mac", mac_addr, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][87:76], VEC[i][75:44]);
      rd(VEC[i][43:32], d);
      chk($sformatf("table row %0d", i), d, VEC[i][31:0]);
    end
    chk("R4 no frame from misaligned ctrl", fs_valid, 0);

    // R7 address load, R8 interrupt
    wr(12'h000, 32'h33221100);
    wr(12'h004, 32'h00005544);
    wr(12'h7F8, 32'h80000000);
    wr(12'h7FC, 32'h0000000B);
    rd(12'h7FC, d); chk("R7 busy bits", d, 32'hB);
    chk("R7 mac not yet", mac_addr, 0);
    @(negedge clk);
    chk("R7 mac loaded", mac_addr, 48'h001122334455);
    chk("R8 irq after load", irq, 1);
    rd(12'h7FC, d); chk("R7 bits cleared", d, 32'h8);
    chk("R7 no frame", fs_valid, 0);
    @(negedge clk);
    chk("R8 irq one cycle", irq, 0);

    // R5 send, R9 ignored rewrite, R6 handshake
    wr(12'h7F4, 32'd64);
    wr(12'h7FC, 32'h00000009);
    rd(12'h7FC, d); chk("R5 busy", d, 32'h9);
    chk("R5 fs_valid", fs_valid, 1);
    chk("R5 fs_base", fs_base, 12'h000);
    chk("R5 fs_len", fs_len, 16'd64);
    wr(12'h7FC, 32'h00000001);
    rd(12'h7FC, d); chk("R9 ie kept", d, 32'h9);
    chk("R6 offer held", fs_valid, 1);
    fs_ready = 1;
    @(negedge clk);
    fs_ready = 0;
    chk("R6 one in flight", fs_valid, 0);
    rd(12'h7FC, d); chk("R5 busy until done", d, 32'h9);
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
    chk("R8 R9 irq on done", irq, 1);
    rd(12'h7FC, d); chk("R5 cleared", d, 32'h8);
    @(negedge clk);
    chk("R8 irq drops", irq, 0);

    // R8 gating with master enable off, R2 clamp on buffer 1
    wr(12'h7F8, 32'h0);
    wr(12'hFF4, 32'd1600);
    wr(12'hFFC, 32'h00000009);
    chk("R5 base buf1", fs_base, 12'h800);
    chk("R2 clamped len", fs_len, 16'd1514);
    accept_done();
    chk("R8 gated irq", irq, 0);
    rd(12'hFFC, d); chk("R5 buf1 cleared", d, 32'h8);

    // R6 standing offer keeps its buffer
    wr(12'hFFC, 32'h00000001);
    chk("R6 offer buf1", fs_base, 12'h800);
    wr(12'h7FC, 32'h00000001);
    chk("R6 base stable", fs_base, 12'h800);
    chk("R6 valid stable", fs_valid, 1);
    accept_done();
    chk("R6 next offer", fs_valid, 1);
    chk("R6 next base", fs_base, 12'h000);
    accept_done();
    rd(12'h7FC, d); chk("R6 buf0 done", d, 32'h0);
    chk("R6 idle", fs_valid, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule